// File: doc/BRIEF.md
# Crystal Time Base with Per-Consumer Timestamp Resolution

This block keeps one free-running counter on the crystal reference clock (nominally 19.2 MHz). The counter does not depend on the main processing clock. Three consumers take timestamps from it: a packet-logging path, a tag path and an address-translation path. Each consumer sees the counter through its own window. The window is a 32-bit slice that starts at a programmable bit and keeps the higher-order bits from there up. A larger starting bit gives a coarser tick and a longer time before the value wraps.

A consumer raises its sample strobe for one cycle to capture a timestamp. The captured value is then held on that consumer's output until its next strobe. The logging path has one extra option: a select bit makes it capture an externally supplied value in place of its counter slice. A single configuration word, written through a plain write-enable port, holds the three starting bits and that select bit.

There is no valid/ready stream at this block's edge. Samples are single-cycle strobes that cannot be refused, and outputs are held registers. Clock-domain crossing toward the consumers is handled outside this block.

Top module: `xtb_time_base`

## Requirements
- R1: A synchronous reset clears the counter, the configuration word and all three timestamp outputs to zero. After reset every starting bit is 0 and the select bit is 0.
- R2: Outside reset, the counter increases by exactly one on every clock edge. Two logging samples on consecutive edges with starting bit 0 therefore differ by one.
- R3: On an edge where the logging strobe is high and the select bit is 0, the logging output captures the counter value held before that edge, shifted right by the logging starting bit (configuration bits [4:0]) and cut to 32 bits. Bits above the top of the counter read as zero.
- R4: Configuration bit [7] set to 1 makes the logging output capture the alternate input in place of the counter slice.
- R5: The tag output captures the counter slice in the same way, using the starting bit in configuration bits [12:8].
- R6: The address-translation output captures the counter slice in the same way, using the starting bit in configuration bits [20:16].
- R7: A timestamp output keeps its value on every edge where its own strobe is low. This holds even when the counter, the configuration or the alternate input changes.
- R8: A configuration write is registered on its clock edge. A sample taken on that same edge still uses the old configuration, and the new configuration applies from the next sample onward.
- R9: A strobe for one consumer leaves the other two outputs unchanged.
- R10: Writes to configuration bits [6:5], [15:13] and [31:21] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal reference clock; the counter advances on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr_en | input | 1 | Writes cfg_wr_data into the configuration word on this edge |
| cfg_wr_data | input | 32 | Configuration word: logging start [4:0], logging select [7], tag start [12:8], translation start [20:16] |
| log_alt_ts | input | 32 | Alternate value captured by the logging path when the select bit is set |
| log_smp | input | 1 | Logging path sample strobe |
| tag_smp | input | 1 | Tag path sample strobe |
| xlat_smp | input | 1 | Address-translation path sample strobe |
| log_ts | output | 32 | Held logging timestamp |
| tag_ts | output | 32 | Held tag timestamp |
| xlat_ts | output | 32 | Held address-translation timestamp |

## Verification
Each timestamp is due one rising edge after its strobe. It carries the counter value from just before that edge, and the configuration as it stood before that edge. A configuration write is visible to the first sample taken one edge or more after the write. The bench drives inputs on falling edges and keeps its own count of edges since reset. For each strobe it records that count on the falling edge before the strobe is taken, and it reads the output on the falling edge that follows. The expected slice therefore pairs with the right counter value and the right configuration word.

// File: rtl/xtb_pkg.sv
package xtb_pkg;

  localparam int CFG_W      = 32;
  localparam int LSB_W      = 5;
  localparam int NUM_CONS   = 3;

  // field positions decoded from the configuration word
  localparam int LOG_LSB_POS  = 0;
  localparam int LOG_SEL_POS  = 7;
  localparam int TAG_LSB_POS  = 8;
  localparam int XLAT_LSB_POS = 16;

  // consumer indices
  localparam int CONS_LOG  = 0;
  localparam int CONS_TAG  = 1;
  localparam int CONS_XLAT = 2;

  typedef struct packed {
    logic [LSB_W-1:0] xlat_lsb;
    logic [LSB_W-1:0] tag_lsb;
    logic             log_alt;
    logic [LSB_W-1:0] log_lsb;
  } xtb_cfg_t;

endpackage

// File: rtl/xtb_counter.sv
module xtb_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o
);

  always_ff @(posedge clk) begin
    if (rst) cnt_o <= '0;
    else     cnt_o <= cnt_o + CNT_W'(1);
  end

  // checking aid: marks that a reset edge has been seen
  logic seen_rst;
  always_ff @(posedge clk) begin
    if (rst) seen_rst <= 1'b1;
  end

  // R1
  cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_rst && $past(rst)) |-> (cnt_o == '0));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_rst && !$past(rst)) |-> (cnt_o == $past(cnt_o) + CNT_W'(1)));

endmodule

// File: rtl/xtb_cfg_reg.sv
module xtb_cfg_reg
  import xtb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output xtb_cfg_t         cfg_o
);

  xtb_cfg_t cfg_d;

  always_comb begin
    cfg_d.log_lsb  = wr_data[LOG_LSB_POS  +: LSB_W];
    cfg_d.log_alt  = wr_data[LOG_SEL_POS];
    cfg_d.tag_lsb  = wr_data[TAG_LSB_POS  +: LSB_W];
    cfg_d.xlat_lsb = wr_data[XLAT_LSB_POS +: LSB_W];
  end

  // reserved bits are deliberately dropped
  logic unused_rsv;
  assign unused_rsv = ^{wr_data[CFG_W-1:XLAT_LSB_POS+LSB_W],
                        wr_data[TAG_LSB_POS+LSB_W +: (XLAT_LSB_POS-TAG_LSB_POS-LSB_W)],
                        wr_data[LOG_LSB_POS+LSB_W +: (LOG_SEL_POS-LOG_LSB_POS-LSB_W)]};

  always_ff @(posedge clk) begin
    if (rst)        cfg_o <= '0;
    else if (wr_en) cfg_o <= cfg_d;
  end

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cfg_o));

  // R1
  cfg_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_o == '0));

endmodule

// File: rtl/xtb_tap.sv
module xtb_tap #(
  parameter int CNT_W = 64,
  parameter int TS_W  = 32,
  parameter int LSB_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [LSB_W-1:0] lsb_i,
  input  logic             use_alt_i,
  input  logic [TS_W-1:0]  alt_i,
  input  logic             smp_i,
  output logic [TS_W-1:0]  ts_o
);

  localparam int EXT_W = (CNT_W > TS_W) ? CNT_W : TS_W;

  logic [EXT_W-1:0] cnt_ext;
  logic [TS_W-1:0]  slice;
  logic [TS_W-1:0]  ts_d;

  // zero-extend so bits above the counter top read as zero
  assign cnt_ext = EXT_W'(cnt_i);
  assign slice   = TS_W'(cnt_ext >> lsb_i);
  assign ts_d    = use_alt_i ? alt_i : slice;

  always_ff @(posedge clk) begin
    if (rst)        ts_o <= '0;
    else if (smp_i) ts_o <= ts_d;
  end

  // R7
  ts_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_i |=> $stable(ts_o));

endmodule

// File: rtl/xtb_time_base.sv
module xtb_time_base
  import xtb_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int TS_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr_en,
  input  logic [CFG_W-1:0] cfg_wr_data,
  input  logic [TS_W-1:0]  log_alt_ts,
  input  logic             log_smp,
  input  logic             tag_smp,
  input  logic             xlat_smp,
  output logic [TS_W-1:0]  log_ts,
  output logic [TS_W-1:0]  tag_ts,
  output logic [TS_W-1:0]  xlat_ts
);

  logic [CNT_W-1:0] cnt;
  xtb_cfg_t         cfg;

  logic [LSB_W-1:0] lsb_a [NUM_CONS];
  logic             smp_a [NUM_CONS];
  logic [TS_W-1:0]  ts_a  [NUM_CONS];

  xtb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .cnt_o (cnt)
  );

  xtb_cfg_reg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .cfg_o   (cfg)
  );

  assign lsb_a[CONS_LOG]  = cfg.log_lsb;
  assign lsb_a[CONS_TAG]  = cfg.tag_lsb;
  assign lsb_a[CONS_XLAT] = cfg.xlat_lsb;
  assign smp_a[CONS_LOG]  = log_smp;
  assign smp_a[CONS_TAG]  = tag_smp;
  assign smp_a[CONS_XLAT] = xlat_smp;

  for (genvar i = 0; i < NUM_CONS; i++) begin : g_tap
    logic use_alt;
    if (i == CONS_LOG) begin : g_alt
      assign use_alt = cfg.log_alt;
    end else begin : g_noalt
      assign use_alt = 1'b0;
    end

    xtb_tap #(.CNT_W(CNT_W), .TS_W(TS_W), .LSB_W(LSB_W)) u_tap (
      .clk       (clk),
      .rst       (rst),
      .cnt_i     (cnt),
      .lsb_i     (lsb_a[i]),
      .use_alt_i (use_alt),
      .alt_i     (log_alt_ts),
      .smp_i     (smp_a[i]),
      .ts_o      (ts_a[i])
    );
  end

  assign log_ts  = ts_a[CONS_LOG];
  assign tag_ts  = ts_a[CONS_TAG];
  assign xlat_ts = ts_a[CONS_XLAT];

  // R4
  log_alt_pick_chk: assert property (@(posedge clk) disable iff (rst)
    (log_smp && cfg.log_alt) |=> (log_ts == $past(log_alt_ts)));

  // R9
  tag_isolate_chk: assert property (@(posedge clk) disable iff (rst)
    (log_smp && !tag_smp) |=> $stable(tag_ts));

endmodule

// File: tb/test_xtb_time_base.sv
module test_xtb_time_base;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_wr_en;
  logic [31:0] cfg_wr_data;
  logic [31:0] log_alt_ts;
  logic        log_smp, tag_smp, xlat_smp;
  logic [31:0] log_ts, tag_ts, xlat_ts;

  int n_chk = 0;
  int n_err = 0;
  logic [63:0] m_cnt;

  always #5 clk = ~clk;

  // edge count since reset, derived from R1/R2
  always @(posedge clk) m_cnt <= rst ? 64'd0 : m_cnt + 64'd1;

  xtb_time_base i_xtb_time_base (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .log_alt_ts(log_alt_ts), .log_smp(log_smp), .tag_smp(tag_smp),
    .xlat_smp(xlat_smp), .log_ts(log_ts), .tag_ts(tag_ts), .xlat_ts(xlat_ts)
  );

  function automatic logic [31:0] sl(logic [63:0] c, int lsb);
    return 32'(c >> lsb);
  endfunction

  function automatic logic [31:0] mk(int llsb, bit sel, int tlsb, int xlsb);
    return 32'(llsb) | (32'(sel) << 7) | (32'(tlsb) << 8) | (32'(xlsb) << 16);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wcfg(logic [31:0] d);
    cfg_wr_en = 1'b1; cfg_wr_data = d;
    @(posedge clk); @(negedge clk);
    cfg_wr_en = 1'b0; cfg_wr_data = '0;
  endtask

  // which: 0 log, 1 tag, 2 xlat
  task automatic smp(int which, output logic [63:0] c);
    log_smp  = (which == 0);
    tag_smp  = (which == 1);
    xlat_smp = (which == 2);
    c = m_cnt;
    @(posedge clk); @(negedge clk);
    log_smp = 1'b0; tag_smp = 1'b0; xlat_smp = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R1 log after reset", log_ts, 32'd0);
    chk("R1 tag after reset", tag_ts, 32'd0);
    chk("R1 xlat after reset", xlat_ts, 32'd0);
  endtask

  task automatic t_count_step();
    logic [63:0] c0, c1;
    logic [31:0] a;
    idle(3);
    smp(0, c0); a = log_ts;
    smp(0, c1);
    chk("R2 first sample", a, sl(c0, 0));
    chk("R2 step of one", log_ts - a, 32'd1);
  endtask

  task automatic t_log_shift();
    logic [63:0] c;
    wcfg(mk(4, 0, 0, 0));
    idle(300);
    smp(0, c);
    chk("R3 log start bit 4", log_ts, sl(c, 4));
    wcfg(mk(9, 0, 0, 0));
    idle(1200);
    smp(0, c);
    chk("R3 log start bit 9", log_ts, sl(c, 9));
    wcfg(mk(31, 0, 0, 0));
    smp(0, c);
    chk("R3 log start bit 31", log_ts, sl(c, 31));
  endtask

  task automatic t_alt_and_hold();
    logic [63:0] c;
    wcfg(mk(0, 1, 0, 0));
    log_alt_ts = 32'hCAFE_1234;
    smp(0, c);
    chk("R4 alternate captured", log_ts, 32'hCAFE_1234);
    log_alt_ts = 32'h0BAD_F00D;
    idle(5);
    chk("R7 held across alt change", log_ts, 32'hCAFE_1234);
    wcfg(mk(2, 0, 0, 0));
    chk("R7 held across cfg write", log_ts, 32'hCAFE_1234);
    smp(0, c);
    chk("R4 select cleared returns slice", log_ts, sl(c, 2));
  endtask

  task automatic t_tag_xlat();
    logic [63:0] c;
    logic [31:0] lg;
    wcfg(mk(0, 0, 3, 7));
    idle(20);
    lg = log_ts;
    smp(1, c);
    chk("R5 tag start bit 3", tag_ts, sl(c, 3));
    chk("R9 log untouched by tag", log_ts, lg);
    idle(40);
    smp(2, c);
    chk("R6 xlat start bit 7", xlat_ts, sl(c, 7));
    chk("R9 log untouched by xlat", log_ts, lg);
  endtask

  task automatic t_indep();
    logic [63:0] c;
    logic [31:0] tg, xl;
    tg = tag_ts; xl = xlat_ts;
    idle(7);
    smp(0, c);
    chk("R9 tag untouched by log", tag_ts, tg);
    chk("R9 xlat untouched by log", xlat_ts, xl);
  endtask

  task automatic t_same_edge();
    logic [63:0] c;
    wcfg(mk(5, 0, 0, 0));
    idle(10);
    cfg_wr_en = 1'b1; cfg_wr_data = mk(1, 0, 0, 0);
    log_smp = 1'b1;
    c = m_cnt;
    @(posedge clk); @(negedge clk);
    cfg_wr_en = 1'b0; log_smp = 1'b0;
    chk("R8 same-edge sample uses old cfg", log_ts, sl(c, 5));
    smp(0, c);
    chk("R8 next sample uses new cfg", log_ts, sl(c, 1));
  endtask

  task automatic t_reserved();
    logic [63:0] c;
    wcfg(mk(6, 0, 2, 11) | 32'hFFE0_E060);
    idle(30);
    smp(0, c);
    chk("R10 reserved bits, log", log_ts, sl(c, 6));
    smp(1, c);
    chk("R10 reserved bits, tag", tag_ts, sl(c, 2));
    smp(2, c);
    chk("R10 reserved bits, xlat", xlat_ts, sl(c, 11));
  endtask

  task automatic t_mid_reset();
    logic [63:0] c;
    wcfg(mk(8, 1, 8, 8));
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    chk("R1 log cleared mid-run", log_ts, 32'd0);
    chk("R1 tag cleared mid-run", tag_ts, 32'd0);
    chk("R1 xlat cleared mid-run", xlat_ts, 32'd0);
    idle(4);
    smp(0, c);
    chk("R1 cfg cleared: log start 0, no alt", log_ts, sl(c, 0));
    smp(1, c);
    chk("R1 cfg cleared: tag start 0", tag_ts, sl(c, 0));
  endtask

  initial begin
    rst = 1'b1; cfg_wr_en = 1'b0; cfg_wr_data = '0; log_alt_ts = '0;
    log_smp = 1'b0; tag_smp = 1'b0; xlat_smp = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_count_step();
    t_log_shift();
    t_alt_and_hold();
    t_tag_xlat();
    t_indep();
    t_same_edge();
    t_reserved();
    t_mid_reset();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule